// File: doc/BRIEF.md
# Phase Offset Stage with Octal PSK Mapping

This block sits between a phase accumulator and a sine/cosine lookup in a numerically controlled oscillator. Each clock it takes the 32-bit accumulator phase and adds a 16-bit offset held in a local register to the upper half of that phase. The lower half passes through untouched. The upper 28 bits of the resulting 32-bit word are registered and presented as the instantaneous phase.

The offset register has two load sources, chosen by a select input. The first is a full 16-bit phase word. The second is a 3-bit modulation code that maps to one of eight phase shifts in 45-degree steps. This allows direct 8-PSK modulation of the carrier from three wires. The register loads only on clock edges where its active-low enable is low. Reset is synchronous and clears both the offset register and the output register.

Top module: `phase_offset_stage`

## Requirements
- R1: While `rst` is high at a rising edge, the offset register and `inst_phase` become zero on that edge.
- R2: One clock after an edge where `rst` is low, `inst_phase` equals bits 31..4 of {acc_phase[31:16] + offset, acc_phase[15:0]}, computed with the offset value held before that edge.
- R3: The 16-bit add at the top of the phase discards its carry out, so the phase wraps modulo 2^32.
- R4: On an edge where `load_n` is low and `src_sel` is 1, the offset register takes `phase_word`.
- R5: On an edge where `load_n` is low and `src_sel` is 0, offset bits 12..0 are loaded as zero and bits 15..13 come from `psk_code`.
- R6: Codes map to these shifts: 000→0°, 001→45°, 010→90°, 011→135°, 100→270°, 101→315°, 110→180°, 111→225°. One 45° step is one count in offset bits 15..13, which gives the values 0,1,2,3,6,7,4,5.
- R7: On an edge where `load_n` is high, the offset register keeps its value, and `phase_word`, `psk_code` and `src_sel` have no effect on later outputs.
- R8: `inst_phase[11:0]` equals `acc_phase[15:4]` from the previous edge, whatever the offset is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| acc_phase | input | 32 | Phase accumulator value |
| phase_word | input | 16 | Full-width offset load value |
| psk_code | input | 3 | Modulation code for the PSK load source |
| src_sel | input | 1 | Offset source: 1 selects phase_word, 0 selects psk_code |
| load_n | input | 1 | Active-low load enable for the offset register |
| inst_phase | output | 28 | Registered instantaneous phase |

## Verification
The bench drives all eight modulation codes with a zero accumulator, so each shift shows up alone in the output. A design that used the codes as a plain binary count would put 180° and 270° in swapped positions. Offsets that push the upper half past 0xFFFF test the wrap: a design that kept the carry, or that let the carry reach the low bits, would give a wrong top field. The bench changes the load data while the enable is high, and it checks the output pass-through of the low half under random offsets. A register that loaded while disabled, or a sum that took the wrong slice, would give a miscompare against the reference on the next clock.

// File: rtl/phoff_pkg.sv
package phoff_pkg;

    // Width of the modulation code and the top-bits field it drives
    localparam int PSK_W = 3;

    // Offset source selection
    typedef enum logic {
        SRC_PSK  = 1'b0,
        SRC_WORD = 1'b1
    } off_src_e;

    // Octant index (count of 45 degree steps) for each modulation code.
    // The code set is not binary ordered: codes 1xx visit 270,315,180,225.
    function automatic logic [PSK_W-1:0] psk_to_octant(input logic [PSK_W-1:0] code);
        return {code[2], code[2] ^ code[1], code[0]};
    endfunction

endpackage

// File: rtl/phoff_psk_map.sv
module phoff_psk_map
    import phoff_pkg::*;
#(
    parameter int OFF_W = 16
) (
    input  logic [PSK_W-1:0] code,
    output logic [OFF_W-1:0] word
);
    localparam int PAD_W = OFF_W - PSK_W;

    logic [PSK_W-1:0] octant;

    always_comb begin
        octant = psk_to_octant(code);
    end

    generate
        if (PAD_W > 0) begin : g_pad
            assign word = {octant, {PAD_W{1'b0}}};
        end else begin : g_nopad
            assign word = octant[PSK_W-1 -: OFF_W];
        end
    endgenerate
endmodule

// File: rtl/phoff_offset_reg.sv
module phoff_offset_reg
    import phoff_pkg::*;
#(
    parameter int OFF_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load_n,
    input  off_src_e         src,
    input  logic [OFF_W-1:0] word_in,
    input  logic [OFF_W-1:0] psk_in,
    output logic [OFF_W-1:0] off_q
);
    logic [OFF_W-1:0] next_off;

    always_comb begin
        unique case (src)
            SRC_WORD: next_off = word_in;
            SRC_PSK:  next_off = psk_in;
            default:  next_off = psk_in;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            off_q <= '0;
        end else if (!load_n) begin
            off_q <= next_off;
        end
    end
endmodule

// File: rtl/phoff_sum_reg.sv
module phoff_sum_reg #(
    parameter int ACC_W = 32,
    parameter int OFF_W = 16,
    parameter int OUT_W = 28
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [ACC_W-1:0] acc,
    input  logic [OFF_W-1:0] off,
    output logic [OUT_W-1:0] phase_q
);
    localparam int LO_W = ACC_W - OFF_W;

    logic [OFF_W-1:0] hi_sum;
    logic [ACC_W-1:0] full;

    always_comb begin
        // carry out of the top bit is dropped: modulo 2^ACC_W wrap
        hi_sum = acc[ACC_W-1:LO_W] + off;
        full   = {hi_sum, acc[LO_W-1:0]};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= '0;
        end else begin
            phase_q <= full[ACC_W-1 -: OUT_W];
        end
    end
endmodule

// File: rtl/phase_offset_stage.sv
module phase_offset_stage
    import phoff_pkg::*;
#(
    parameter int ACC_W = 32,
    parameter int OFF_W = 16,
    parameter int OUT_W = 28
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [ACC_W-1:0] acc_phase,
    input  logic [OFF_W-1:0] phase_word,
    input  logic [PSK_W-1:0] psk_code,
    input  logic             src_sel,
    input  logic             load_n,
    output logic [OUT_W-1:0] inst_phase
);
    logic [OFF_W-1:0] psk_word;
    logic [OFF_W-1:0] off_q;
    off_src_e         src;

    assign src = off_src_e'(src_sel);

    phoff_psk_map #(.OFF_W(OFF_W)) u_map (
        .code (psk_code),
        .word (psk_word)
    );

    phoff_offset_reg #(.OFF_W(OFF_W)) u_off (
        .clk     (clk),
        .rst     (rst),
        .load_n  (load_n),
        .src     (src),
        .word_in (phase_word),
        .psk_in  (psk_word),
        .off_q   (off_q)
    );

    phoff_sum_reg #(.ACC_W(ACC_W), .OFF_W(OFF_W), .OUT_W(OUT_W)) u_sum (
        .clk     (clk),
        .rst     (rst),
        .acc     (acc_phase),
        .off     (off_q),
        .phase_q (inst_phase)
    );
endmodule

// File: rtl/phase_offset_stage_chk.sv
module phase_offset_stage_chk (
    input logic        clk,
    input logic        rst,
    input logic [31:0] acc_phase,
    input logic [15:0] phase_word,
    input logic [2:0]  psk_code,
    input logic        src_sel,
    input logic        load_n,
    input logic [15:0] off_q,
    input logic [27:0] inst_phase
);
    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (inst_phase == 28'd0 && off_q == 16'd0));

    a_r2_r3_top_sum: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> inst_phase[27:12] == 16'($past(acc_phase[31:16]) + $past(off_q)));

    a_r4_word_load: assert property (@(posedge clk) disable iff (rst)
        (!load_n && src_sel) |=> off_q == $past(phase_word));

    a_r5_low_cleared: assert property (@(posedge clk) disable iff (rst)
        (!load_n && !src_sel) |=> off_q[12:0] == 13'd0);

    a_r6_code_100: assert property (@(posedge clk) disable iff (rst)
        (!load_n && !src_sel && psk_code == 3'b100) |=> off_q[15:13] == 3'd6);

    a_r6_code_110: assert property (@(posedge clk) disable iff (rst)
        (!load_n && !src_sel && psk_code == 3'b110) |=> off_q[15:13] == 3'd4);

    a_r7_hold: assert property (@(posedge clk) disable iff (rst)
        load_n |=> $stable(off_q));

    a_r8_low_pass: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> inst_phase[11:0] == $past(acc_phase[15:4]));
endmodule

bind phase_offset_stage phase_offset_stage_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .acc_phase  (acc_phase),
    .phase_word (phase_word),
    .psk_code   (psk_code),
    .src_sel    (src_sel),
    .load_n     (load_n),
    .off_q      (off_q),
    .inst_phase (inst_phase)
);

// File: tb/sim_phase_offset_stage.sv
module sim_phase_offset_stage;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] acc_phase = '0;
    logic [15:0] phase_word = '0;
    logic [2:0]  psk_code = '0;
    logic        src_sel = 1'b0;
    logic        load_n = 1'b1;
    logic [27:0] inst_phase;

    int    vectors = 0;
    int    miscompares = 0;
    bit    done = 1'b0;
    string cur_req = "R1";

    // reference state
    longint m_off = 0;
    longint m_out = 0;

    always #10 clk = ~clk;

    phase_offset_stage u0 (
        .clk        (clk),
        .rst        (rst),
        .acc_phase  (acc_phase),
        .phase_word (phase_word),
        .psk_code   (psk_code),
        .src_sel    (src_sel),
        .load_n     (load_n),
        .inst_phase (inst_phase)
    );

    // R6: shift in degrees per code
    function automatic int code_deg(input int c);
        case (c)
            0: return 0;   1: return 45;  2: return 90;  3: return 135;
            4: return 270; 5: return 315; 6: return 180; default: return 225;
        endcase
    endfunction

    // reference: behavioural, integer arithmetic
    always @(posedge clk) begin
        if (rst) begin
            m_off = 0;
            m_out = 0;
        end else begin
            longint hi;
            longint total;
            hi    = ((longint'(acc_phase) >> 16) + m_off) % 65536;  // R3 wrap
            total = hi * 65536 + (longint'(acc_phase) % 65536);
            m_out = total / 16;
            if (!load_n) begin
                if (src_sel) m_off = longint'(phase_word);
                else         m_off = (longint'(code_deg(int'(psk_code))) / 45) * 8192;
            end
        end
    end

    always @(negedge clk) begin
        if (!done) begin
            vectors++;
            if (longint'(inst_phase) != m_out) begin
                miscompares++;
                $display("FAIL %s: inst_phase=%07h expected=%07h", cur_req, inst_phase, m_out[27:0]);
            end
        end
    end

    task automatic step(input logic [31:0] a, input logic [15:0] w, input logic [2:0] c,
                        input logic s, input logic ln);
        @(negedge clk);
        #2;
        acc_phase = a; phase_word = w; psk_code = c; src_sel = s; load_n = ln;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(acc_phase, phase_word, psk_code, src_sel, 1'b1);
    endtask

    initial begin
        #400000;
        if (!done) begin
            done = 1'b1;
            miscompares++;
            $display("FAIL watchdog: expected run end, got timeout");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        // R1: reset state, with busy inputs during reset
        cur_req = "R1";
        step(32'hFFFF_FFFF, 16'hABCD, 3'b111, 1'b1, 1'b0);
        step(32'h1234_5678, 16'hABCD, 3'b111, 1'b1, 1'b0);
        @(negedge clk); #2; rst = 1'b0;
        acc_phase = '0; load_n = 1'b1;
        idle(2);

        // R6 / R5: each code alone against a zero accumulator
        cur_req = "R6";
        for (int c = 0; c < 8; c++) begin
            step(32'h0, 16'hFFFF, 3'(c), 1'b0, 1'b0);
            step(32'h0, 16'hFFFF, 3'(c), 1'b0, 1'b1);
            idle(1);
        end

        // R4: full word loads
        cur_req = "R4";
        step(32'h0, 16'h1357, 3'b000, 1'b1, 1'b0);
        step(32'h0000_ABCD, 16'h0, 3'b000, 1'b1, 1'b1);
        idle(2);

        // R7: load data moves while enable is high
        cur_req = "R7";
        for (int i = 0; i < 6; i++)
            step(32'h0101_0101 * i, 16'(16'h1111 * (i + 3)), 3'(i), 1'(i), 1'b1);

        // R3: wrap of the top half
        cur_req = "R3";
        step(32'hFFF0_0000, 16'h0020, 3'b000, 1'b1, 1'b0);
        step(32'hFFF0_FFFF, 16'h0, 3'b000, 1'b1, 1'b1);
        step(32'hFFFF_FFFF, 16'h0, 3'b000, 1'b1, 1'b1);
        step(32'h0, 16'hFFFF, 3'b000, 1'b1, 1'b0);
        step(32'h0001_0000, 16'h0, 3'b000, 1'b1, 1'b1);
        step(32'hFFFF_FFF0, 16'h0, 3'b000, 1'b1, 1'b1);
        idle(1);

        // R8 / R2: random traffic, mixed sources and enables
        cur_req = "R2/R8";
        for (int i = 0; i < 400; i++)
            step($urandom, 16'($urandom), 3'($urandom), 1'($urandom), 1'($urandom));

        // R5: PSK load right after a full word leaves no low bits behind
        cur_req = "R5";
        step(32'h0, 16'hFFFF, 3'b001, 1'b1, 1'b0);
        step(32'h0, 16'hFFFF, 3'b001, 1'b0, 1'b0);
        step(32'h0000_FFFF, 16'h0, 3'b001, 1'b0, 1'b1);
        idle(2);

        // R1: reset mid-run clears a loaded offset
        cur_req = "R1";
        step(32'h8000_0000, 16'h7777, 3'b000, 1'b1, 1'b0);
        @(negedge clk); #2; rst = 1'b1;
        @(negedge clk); #2; rst = 1'b0; acc_phase = 32'h0; load_n = 1'b1;
        idle(2);

        @(negedge clk);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule